// File: doc/BRIEF.md
# Voltage ID Stepping Controller

This block owns the 6-bit voltage identification code that an external regulator follows. Once the start control input is high, it asks the fuse path for a default code and offers that code to the regulator-side consumer. After the consumer accepts a code, the block waits a programmable number of microseconds and then computes the next code. The microsecond tick comes from a clock prescaler.

The next code depends on the mode. When the adaptive feature is not fully enabled (static mode), a code below the nominal 0.9 V code (48) is raised toward 48 in programmable steps. When all four enable terms are high and the extended temperature grade is selected (adaptive mode), the code is lowered by the step on each computation. It never goes below the 0.8 V floor code (28). The voltage is (code − 28) × 5 mV + 0.8 V, and one step unit is one code LSB.

The code leaves on a valid/ready pair. `code_avail_o` is valid and `code_ack_i` is ready. A code transfers on a clock edge where both are high. While valid is high and ready is low, the consumer is back-pressuring: the code and valid hold unchanged. No new code is computed until the previous one has been accepted and the delay has run out.

Top module: `vid_step_ctrl`

## Requirements
- R1: After reset, `fuse_req_o` stays low until `start_i` is sampled high. When `fuse_valid_i` is then sampled high, `fuse_code_i` appears on `code_o` with `code_avail_o` high on the next cycle.
- R2: While `code_avail_o` is high and `code_ack_i` is low, `code_o` and `code_avail_o` hold. On an edge where both are high the code is taken, and `code_avail_o` is low afterwards.
- R3: In static mode (enable AND low), a computation on a code below 48 offers min(code + step, 48). A code of 48 or more is never re-offered.
- R4: In adaptive mode with `grade_ext_i` high, a computation offers max(code − step, 28).
- R5: Adaptive mode needs `dyn_en_i`, `fuse_en_i`, `dev_support_i` and `fuse_bit4_i` all high. With any one of them low, the block stays in static mode.
- R6: `active_o` rises only at the first computation made with the enable AND high, which comes after the default code has been taken and the delay has expired. While active, `latest_code_o` shows the last code computed in adaptive mode; otherwise it is 0.
- R7: A computation happens `delay_us_i` × US_DIV + 1 clock cycles after the edge on which the previous code was taken. Any new code is offered on that edge.
- R8: A computation that leaves the code unchanged offers nothing and restarts the delay. This covers the floor at 28 and adaptive mode with `grade_ext_i` low.
- R9: When the enable AND drops, `active_o` and `latest_code_o` are 0 from the next cycle, and static ramping resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-operation control bit |
| dyn_en_i | input | 1 | Dynamic adaptive-enable control bit |
| fuse_en_i | input | 1 | Adaptive-enable status bit |
| dev_support_i | input | 1 | Device-supports status bit |
| fuse_bit4_i | input | 1 | Fuse enable bit |
| grade_ext_i | input | 1 | Extended temperature grade selected |
| step_i | input | 6 | Step size in code LSBs (5 mV each) |
| delay_us_i | input | 20 | Computation delay in microseconds |
| fuse_req_o | output | 1 | Request for the fuse default code |
| fuse_valid_i | input | 1 | Fuse default code valid |
| fuse_code_i | input | 6 | Fuse default code |
| code_ack_i | input | 1 | Consumer ready / acknowledge |
| code_o | output | 6 | Voltage identification code |
| code_avail_o | output | 1 | Code valid |
| active_o | output | 1 | Adaptive mode active |
| latest_code_o | output | 6 | Latest adaptive code, 0 when inactive |

## Verification
`fuse_req_o` is due one cycle after `start_i` is sampled. The default code and its valid are due one cycle after `fuse_valid_i` is sampled. A computed code is due exactly delay × US_DIV + 1 edges after the accepting edge. `active_o` and `latest_code_o` clear one edge after the enable AND drops. The bench drives and samples on falling edges only. It counts rising edges from the accepting edge and checks that valid is still low one cycle before the due edge and high right after it. Where no offer is expected, the bench watches for several full delay periods; where the exact timing is not under test, it polls with a bound.

// File: rtl/vid_step_pkg.sv
package vid_step_pkg;
  localparam int unsigned CODE_W = 6;
  localparam logic [CODE_W-1:0] CODE_FLOOR   = 6'd28;
  localparam logic [CODE_W-1:0] CODE_NOMINAL = 6'h30;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_OFFER,
    ST_WAIT
  } ctl_state_e;
endpackage

// File: rtl/vid_us_timer.sv
module vid_us_timer #(
  parameter int unsigned US_DIV  = 125,
  parameter int unsigned DELAY_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic               elapsed_o
);
  localparam int unsigned PRE_W = (US_DIV > 1) ? $clog2(US_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(US_DIV - 1);
  localparam logic [DELAY_W-1:0] US_MAX = '1;

  logic [PRE_W-1:0]   pre_q;
  logic [DELAY_W-1:0] us_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (pre_q == PRE_LAST) begin
      pre_q <= '0;
      if (us_q != US_MAX) us_q <= us_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign elapsed_o = (us_q >= delay_i);
endmodule

// File: rtl/vid_code_math.sv
module vid_code_math
  import vid_step_pkg::*;
(
  input  logic [CODE_W-1:0] cur_i,
  input  logic [CODE_W-1:0] step_i,
  input  logic              down_i,
  output logic [CODE_W-1:0] nxt_o,
  output logic              differs_o
);
  logic [CODE_W:0] sum_w;
  logic [CODE_W:0] low_lim_w;

  always_comb begin
    sum_w     = {1'b0, cur_i} + {1'b0, step_i};
    low_lim_w = {1'b0, step_i} + {1'b0, CODE_FLOOR};
    if (down_i) begin
      // saturate at the floor code rather than wrapping below it
      if ({1'b0, cur_i} < low_lim_w) nxt_o = CODE_FLOOR;
      else                            nxt_o = cur_i - step_i;
    end else begin
      // ramp toward the nominal code, never past it
      if (cur_i >= CODE_NOMINAL)              nxt_o = cur_i;
      else if (sum_w >= {1'b0, CODE_NOMINAL}) nxt_o = CODE_NOMINAL;
      else                                    nxt_o = sum_w[CODE_W-1:0];
    end
    differs_o = (nxt_o != cur_i);
  end
endmodule

// File: rtl/vid_code_reg.sv
module vid_code_reg
  import vid_step_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] load_code_i,
  input  logic              ack_i,
  output logic [CODE_W-1:0] code_o,
  output logic              avail_o,
  output logic              xfer_o
);
  assign xfer_o = avail_o & ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o  <= '0;
      avail_o <= 1'b0;
    end else if (load_i) begin
      code_o  <= load_code_i;
      avail_o <= 1'b1;
    end else if (xfer_o) begin
      avail_o <= 1'b0;
    end
  end

  // R2: an offered code holds under back-pressure
  a_r2_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_o && !ack_i) |=> (avail_o && $stable(code_o)));

  // R2: a new code is never loaded over one not yet taken
  a_r2_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !avail_o);
endmodule

// File: rtl/vid_step_ctrl.sv
module vid_step_ctrl
  import vid_step_pkg::*;
#(
  parameter int unsigned US_DIV  = 125,
  parameter int unsigned DELAY_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               dyn_en_i,
  input  logic               fuse_en_i,
  input  logic               dev_support_i,
  input  logic               fuse_bit4_i,
  input  logic               grade_ext_i,
  input  logic [CODE_W-1:0]  step_i,
  input  logic [DELAY_W-1:0] delay_us_i,
  output logic               fuse_req_o,
  input  logic               fuse_valid_i,
  input  logic [CODE_W-1:0]  fuse_code_i,
  input  logic               code_ack_i,
  output logic [CODE_W-1:0]  code_o,
  output logic               code_avail_o,
  output logic               active_o,
  output logic [CODE_W-1:0]  latest_code_o
);
  ctl_state_e        state_q, state_d;
  logic              en_all;
  logic              elapsed;
  logic              timer_clr;
  logic              xfer;
  logic [CODE_W-1:0] calc_code;
  logic              calc_differs;
  logic              do_compute;
  logic              do_step;
  logic              load;
  logic [CODE_W-1:0] load_code;
  logic              active_q;
  logic [CODE_W-1:0] latest_q;

  assign en_all = dyn_en_i & fuse_en_i & dev_support_i & fuse_bit4_i;

  vid_us_timer #(.US_DIV(US_DIV), .DELAY_W(DELAY_W)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (timer_clr),
    .delay_i   (delay_us_i),
    .elapsed_o (elapsed)
  );

  vid_code_math math_i (
    .cur_i     (code_o),
    .step_i    (step_i),
    .down_i    (en_all),
    .nxt_o     (calc_code),
    .differs_o (calc_differs)
  );

  vid_code_reg creg_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .load_code_i (load_code),
    .ack_i       (code_ack_i),
    .code_o      (code_o),
    .avail_o     (code_avail_o),
    .xfer_o      (xfer)
  );

  assign do_compute = (state_q == ST_WAIT) && elapsed;
  // adaptive mode only moves the code for the extended grade
  assign do_step    = do_compute && calc_differs && (!en_all || grade_ext_i);
  assign timer_clr  = (state_q != ST_WAIT) || elapsed;
  assign fuse_req_o = (state_q == ST_FETCH);

  always_comb begin
    load      = 1'b0;
    load_code = calc_code;
    state_d   = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_FETCH;
      ST_FETCH: if (fuse_valid_i) begin
        load      = 1'b1;
        load_code = fuse_code_i;
        state_d   = ST_OFFER;
      end
      ST_OFFER: if (xfer) state_d = ST_WAIT;
      ST_WAIT:  if (do_step) begin
        load    = 1'b1;
        state_d = ST_OFFER;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      active_q <= 1'b0;
      latest_q <= '0;
    end else begin
      state_q <= state_d;
      if (!en_all) begin
        active_q <= 1'b0;
        latest_q <= '0;
      end else begin
        if (do_compute) active_q <= 1'b1;
        if (do_step)    latest_q <= calc_code;
      end
    end
  end

  assign active_o      = active_q;
  assign latest_code_o = latest_q;

  // R1: no fuse request unless start was sampled
  a_r1_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fuse_req_o) |-> $past(start_i));

  // R4: an adaptive step never lands below the floor code
  a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && en_all) |=> (code_o >= CODE_FLOOR));

  // R3: a static step never lands above the nominal code
  a_r3_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && !en_all) |=> (code_o <= CODE_NOMINAL));

  // R9: losing an enable term drops active status
  a_r9_drop_active: assert property (@(posedge clk) disable iff (!rst_n)
    !en_all |=> (!active_o && latest_code_o == '0));
endmodule

// File: tb/vid_step_ctrl_tb_top.sv
module vid_step_ctrl_tb_top;
  localparam int unsigned DIV = 4;
  localparam int unsigned DLY = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, dyn_en_i = 0, fuse_en_i = 0, dev_support_i = 0;
  logic fuse_bit4_i = 0, grade_ext_i = 0, fuse_valid_i = 0, code_ack_i = 0;
  logic [5:0]  step_i = 0, fuse_code_i = 0;
  logic [19:0] delay_us_i = 20'(DLY);
  logic        fuse_req_o, code_avail_o, active_o;
  logic [5:0]  code_o, latest_code_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vid_step_ctrl #(.US_DIV(DIV), .DELAY_W(20)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dyn_en_i(dyn_en_i),
    .fuse_en_i(fuse_en_i), .dev_support_i(dev_support_i),
    .fuse_bit4_i(fuse_bit4_i), .grade_ext_i(grade_ext_i), .step_i(step_i),
    .delay_us_i(delay_us_i), .fuse_req_o(fuse_req_o),
    .fuse_valid_i(fuse_valid_i), .fuse_code_i(fuse_code_i),
    .code_ack_i(code_ack_i), .code_o(code_o), .code_avail_o(code_avail_o),
    .active_o(active_o), .latest_code_o(latest_code_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ack_once();
    @(negedge clk) code_ack_i = 1'b1;
    @(negedge clk) code_ack_i = 1'b0;
  endtask

  // ack, then check the next offer arrives exactly DLY*DIV+1 edges later
  task automatic ack_timed(input string req);
    @(negedge clk) code_ack_i = 1'b1;
    @(negedge clk) code_ack_i = 1'b0;
    repeat (DLY * DIV) @(negedge clk);
    chk(code_avail_o == 1'b0, req, code_avail_o, 0);
    @(negedge clk);
    chk(code_avail_o == 1'b1, req, code_avail_o, 1);
  endtask

  task automatic poll_avail(input int limit, output bit got);
    got = 0;
    for (int i = 0; i < limit && !got; i++) begin
      @(negedge clk);
      if (code_avail_o) got = 1;
    end
  endtask

  task automatic quiet_window(input string req);
    bit seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (code_avail_o) seen = 1;
    end
    chk(!seen, req, seen, 0);
  endtask

  task automatic t_reset();
    chk(code_o == 0 && !code_avail_o && !fuse_req_o && !active_o
        && latest_code_o == 0, "R1 reset state", code_o, 0);
  endtask

  task automatic t_start_gate();
    repeat (10) @(negedge clk);
    chk(!fuse_req_o, "R1 no request before start", fuse_req_o, 0);
    start_i = 1'b1;
    @(negedge clk);
    chk(fuse_req_o, "R1 request after start", fuse_req_o, 1);
    fuse_code_i = 6'd42; fuse_valid_i = 1'b1;
    @(negedge clk);
    fuse_valid_i = 1'b0;
    chk(code_avail_o && code_o == 6'd42, "R1 default offered", code_o, 42);
  endtask

  task automatic t_hold();
    bit moved = 0;
    fuse_code_i = 6'd5;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!code_avail_o || code_o != 6'd42) moved = 1;
    end
    chk(!moved, "R2 hold under back-pressure", code_o, 42);
  endtask

  task automatic t_static_ramp();
    step_i = 6'd4;
    ack_timed("R7 static step timing");
    chk(code_o == 6'd46, "R3 static step", code_o, 46);
    chk(!active_o && latest_code_o == 0, "R6 inactive in static", active_o, 0);
    ack_timed("R7 second step timing");
    chk(code_o == 6'd48, "R3 clamp at nominal", code_o, 48);
    ack_once();
    chk(!code_avail_o, "R2 valid drops after transfer", code_avail_o, 0);
    quiet_window("R3 no offer at nominal");
  endtask

  task automatic t_enable_and();
    dyn_en_i = 1; fuse_en_i = 1; dev_support_i = 1; grade_ext_i = 1;
    quiet_window("R5 three terms stay static");
    chk(!active_o, "R5 not active with three terms", active_o, 0);
  endtask

  task automatic t_adaptive();
    bit got;
    @(negedge clk) begin fuse_bit4_i = 1; step_i = 6'd3; end
    poll_avail(40, got);
    chk(got && code_o == 6'd45, "R4 adaptive step down", code_o, 45);
    chk(active_o && latest_code_o == 6'd45, "R6 active with latest", latest_code_o, 45);
    ack_once();
  endtask

  task automatic t_other_grade();
    grade_ext_i = 0;
    quiet_window("R8 no change for other grade");
    chk(active_o && latest_code_o == 6'd45, "R6 active holds", latest_code_o, 45);
  endtask

  task automatic t_floor();
    bit got;
    @(negedge clk) begin grade_ext_i = 1; step_i = 6'd20; end
    poll_avail(40, got);
    chk(got && code_o == 6'd28, "R4 saturate at floor", code_o, 28);
    ack_once();
    quiet_window("R8 no offer at floor");
  endtask

  task automatic t_disable();
    bit got;
    @(negedge clk) dyn_en_i = 0;
    @(negedge clk);
    chk(!active_o && latest_code_o == 0, "R9 drop active", latest_code_o, 0);
    poll_avail(40, got);
    chk(got && code_o == 6'd48, "R9 static resumes to nominal", code_o, 48);
    ack_once();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_start_gate();
    t_hold();
    t_static_ramp();
    t_enable_and();
    t_adaptive();
    t_other_grade();
    t_floor();
    t_disable();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule